// File: doc/BRIEF.md
# Four-Way Interleaved Memory Controller

The controller connects one requester to four memory modules. Each access goes to the module chosen by the two lowest address bits. The remaining address bits pick a word inside that module. Every module captures its own copy of the word address and write data from a shared address bus and a shared data bus. It then works through a fixed access time of `LAT` cycles without further help. A new request for a different module can therefore be accepted while earlier accesses are still in flight. A stream of consecutive addresses runs at one access per clock whenever `LAT` does not exceed the number of modules.

A request for a module that is still mid-access is held off: `ready_o` stays low until that module is in its final busy cycle. A module may take a new request in the same edge that ends its current access. Read results return on one shared bus, in the order the reads were accepted. A small queue of module tags decides which module's data drives the bus in each cycle.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: After reset, `rvalid_o` is 0 and `ready_o` is 1 for any address, because all modules are idle.
- R2: Address bits [1:0] select the module and bits [ADDR_W-1:2] select the word within it. A read of any address returns the value most recently written to that same address.
- R3: A read accepted at clock edge k presents its data with `rvalid_o` high in the cycle that follows edge k+LAT.
- R4: Requests to modules that are free are accepted one per cycle. With LAT=4, a run of consecutive addresses is accepted on consecutive edges with `ready_o` never low.
- R5: A module stays busy for LAT cycles after it accepts a request. A request to that module sees `ready_o` low, is not taken, and is accepted LAT edges after the previous one (LAT-1 stalled cycles). Same-module requests are therefore accepted every LAT cycles.
- R6: Read data returns in acceptance order, at most one item per cycle, and only one module drives the shared read bus in any cycle.
- R7: A write (`we_i`=1) never raises `rvalid_o`. A read accepted after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request valid |
| addr_i | input | ADDR_W | Word address; low two bits select the module |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Request accepted at this edge if `req_i` is high |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | DATA_W | Read data |

## Verification
The bench builds the controller with ADDR_W=8, DATA_W=16 and LAT=4, which makes the access time equal to the number of modules. With these values, a sequential stream is exactly at the edge of full rate: each module becomes free in the same edge in which the stream comes back to it. A stride of four lands every request on one module and exposes the full LAT-1 stall window. Mixed module orders, read-after-write to one address, and a write-only phase check in-order return, data placement and the absence of spurious read strobes.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {OP_RD = 1'b0, OP_WR = 1'b1} op_e;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank
  import ilv_pkg::*;
#(
  parameter int WORD_W = 6,
  parameter int DATA_W = 16,
  parameter int LAT    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              free_o,
  output logic              rd_done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WORDS = 1 << WORD_W;
  localparam int CNT_W = $clog2(LAT + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  op_e               op_q;
  logic [DATA_W-1:0] mem [WORDS];
  logic              last_cyc;

  assign last_cyc  = (cnt_q == CNT_W'(1));
  // free when idle or finishing this cycle
  assign free_o    = (cnt_q == '0) || last_cyc;
  assign rd_done_o = last_cyc && (op_q == OP_RD);
  assign rdata_o   = mem[addr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      op_q   <= OP_RD;
    end else if (accept_i) begin
      cnt_q  <= CNT_W'(LAT);
      addr_q <= word_i;
      data_q <= wdata_i;
      op_q   <= we_i ? OP_WR : OP_RD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (last_cyc && op_q == OP_WR) mem[addr_q] <= data_q;
  end

  // R5
  busy_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |-> (cnt_q <= CNT_W'(1)));

  // R5
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> (cnt_q == CNT_W'(LAT)));

  // R3
  finish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_cyc && !accept_i) |=> (cnt_q == '0));
endmodule

// File: rtl/ilv_tag_fifo.sv
module ilv_tag_fifo #(
  parameter int TAG_W = 2,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             pop_i,
  output logic [TAG_W-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic [TAG_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign head_o  = slot_q[rd_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      if (push_i) begin
        slot_q[wr_q] <= tag_i;
        wr_q         <= nxt(wr_q);
      end
      if (pop_i) rd_q <= nxt(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CNT_W'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |-> pop_i);

  // R6
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int MOD_BITS = 2,
  parameter int LAT      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int NUM_MOD = 1 << MOD_BITS;
  localparam int WORD_W  = ADDR_W - MOD_BITS;

  logic [MOD_BITS-1:0] sel;
  logic [WORD_W-1:0]   word_bus;
  logic [DATA_W-1:0]   data_bus;
  logic                accept;
  logic [NUM_MOD-1:0]  bank_free, bank_acc, rd_done;
  logic [DATA_W-1:0]   bank_rdata [NUM_MOD];
  logic [MOD_BITS-1:0] head;
  logic                q_empty, q_full, pop;

  assign sel      = addr_i[MOD_BITS-1:0];
  assign word_bus = addr_i[ADDR_W-1:MOD_BITS];
  assign data_bus = wdata_i;
  assign ready_o  = bank_free[sel];
  assign accept   = req_i && ready_o;

  for (genvar g = 0; g < NUM_MOD; g++) begin : g_bank
    assign bank_acc[g] = accept && (sel == MOD_BITS'(g));
    ilv_bank #(.WORD_W(WORD_W), .DATA_W(DATA_W), .LAT(LAT)) bank_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .accept_i  (bank_acc[g]),
      .we_i      (we_i),
      .word_i    (word_bus),
      .wdata_i   (data_bus),
      .free_o    (bank_free[g]),
      .rd_done_o (rd_done[g]),
      .rdata_o   (bank_rdata[g])
    );
  end

  assign pop = rd_done[head];

  ilv_tag_fifo #(.TAG_W(MOD_BITS), .DEPTH(NUM_MOD)) tags_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (accept && !we_i),
    .tag_i   (sel),
    .pop_i   (pop),
    .head_o  (head),
    .empty_o (q_empty),
    .full_o  (q_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= pop;
      if (pop) rdata_o <= bank_rdata[head];
    end
  end

  // R6
  one_driver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_done));

  // R6
  head_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rd_done) |-> (rd_done[head] && !q_empty));

  // R6
  full_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !we_i && q_full) |-> pop);
endmodule

// File: tb/ilv_mem_ctrl_tb_top.sv
`timescale 1ns/1ps
module ilv_mem_ctrl_tb_top;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int LAT    = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              we_i = 1'b0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic              ready_o, rvalid_o;
  logic [DATA_W-1:0] rdata_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int acc = 0, prev_acc = 0, stalls = 0, rv_seen = 0;
  logic [DATA_W-1:0] ref_mem [1 << ADDR_W];
  logic [DATA_W-1:0] exp_data [$];
  int                exp_cyc [$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ilv_mem_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MOD_BITS(2), .LAT(LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .ready_o(ready_o), .rvalid_o(rvalid_o), .rdata_o(rdata_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rvalid_o) begin
      rv_seen++;
      if (exp_data.size() == 0) begin
        chk(1'b0, "R7 unexpected read strobe", 1, 0);
      end else begin
        logic [DATA_W-1:0] ed;
        int ec;
        ed = exp_data.pop_front();
        ec = exp_cyc.pop_front();
        chk(rdata_o == ed, "R2/R6 read data", int'(rdata_o), int'(ed));
        chk(cyc == ec, "R3 read latency", cyc, ec);
      end
    end
  end

  function automatic logic [DATA_W-1:0] pat(input int a, input int salt);
    return DATA_W'((a * 37) ^ salt);
  endfunction

  // called at a negedge; returns at the negedge after acceptance
  task automatic issue(input int a, input bit w, input logic [DATA_W-1:0] d);
    int st;
    st = 0;
    req_i = 1'b1; addr_i = ADDR_W'(a); we_i = w; wdata_i = d;
    #1;
    while (!ready_o) begin
      st++;
      @(negedge clk); #1;
    end
    @(negedge clk);
    stalls = st;
    prev_acc = acc;
    acc = cyc;
    if (w) ref_mem[a] = d;
    else begin
      exp_data.push_back(ref_mem[a]);
      exp_cyc.push_back(cyc + LAT);
    end
    req_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_data.size() != 0) @(negedge clk);
    repeat (LAT + 2) @(negedge clk);
  endtask

  initial begin
    #200000;
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rvalid_o == 1'b0, "R1 rvalid after reset", int'(rvalid_o), 0);
    for (int a = 0; a < 4; a++) begin
      addr_i = ADDR_W'(a); #1;
      chk(ready_o == 1'b1, "R1 ready after reset", int'(ready_o), 1);
    end
    addr_i = '0;
    @(negedge clk);

    // R4 / R7 sequential writes, full rate, no read strobe
    rv_seen = 0;
    for (int a = 0; a < 16; a++) begin
      issue(a, 1'b1, pat(a, 16'hA5A5));
      if (a > 0) begin
        chk(stalls == 0, "R4 sequential write stalls", stalls, 0);
        chk(acc - prev_acc == 1, "R4 sequential write spacing", acc - prev_acc, 1);
      end
    end
    drain();
    chk(rv_seen == 0, "R7 writes raise no rvalid", rv_seen, 0);

    // R2 / R3 / R4 / R6 sequential reads
    for (int a = 0; a < 16; a++) begin
      issue(a, 1'b0, '0);
      if (a > 0) begin
        chk(stalls == 0, "R4 sequential read stalls", stalls, 0);
        chk(acc - prev_acc == 1, "R4 sequential read spacing", acc - prev_acc, 1);
      end
    end
    drain();
    chk(rv_seen == 16, "R6 read count", rv_seen, 16);

    // R5 same-module stride writes then reads
    for (int i = 0; i < 4; i++) begin
      issue(i * 4, 1'b1, pat(i * 4, 16'h3C00));
      if (i > 0) begin
        chk(stalls == LAT - 1, "R5 busy stall cycles", stalls, LAT - 1);
        chk(acc - prev_acc == LAT, "R5 same-module spacing", acc - prev_acc, LAT);
      end
    end
    for (int i = 0; i < 4; i++) begin
      issue(i * 4, 1'b0, '0);
      chk(stalls == LAT - 1, "R5 read after busy module", stalls, LAT - 1);
    end
    drain();

    // R7 read-after-write same address
    @(negedge clk);
    issue(21, 1'b1, 16'hBEEF);
    issue(21, 1'b0, '0);
    chk(stalls == LAT - 1, "R7 read waits for write module", stalls, LAT - 1);
    drain();

    // R2 / R6 mixed module order, addresses differing only in low bits
    for (int a = 32; a < 40; a++) issue(a, 1'b1, pat(a, 16'h0F0F));
    drain();
    begin
      int ord [8] = '{35, 33, 34, 32, 39, 37, 38, 36};
      for (int i = 0; i < 8; i++) begin
        issue(ord[i], 1'b0, '0);
        if (i > 0) chk(stalls == 0, "R4 mixed order stalls", stalls, 0);
      end
    end
    drain();

    // upper word bits: same module, different words
    issue(64 + 1, 1'b1, 16'h1234);
    issue(128 + 1, 1'b1, 16'h5678);
    issue(64 + 1, 1'b0, '0);
    issue(128 + 1, 1'b0, '0);
    issue(1, 1'b0, '0);
    drain();
    chk(exp_data.size() == 0, "R6 queue drained", exp_data.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule